// File: doc/BRIEF.md
# Drift-Compensated Nanosecond Time-of-Day Counter

This block holds a 64-bit time-of-day value in nanoseconds for a precision time protocol clock. Each reference clock cycle a 32-bit frequency-trim word is summed into a 32-bit phase accumulator. Whenever that sum overflows, the time value grows by a programmable nominal step in nanoseconds. Software tunes the effective rate by rewriting the trim word while the clock runs. A bypass mode instead adds the step on every cycle.

Software reaches the block through a simple single-cycle register port. The time value is split into two 32-bit words. A write of the lower word is held in staging and takes effect only when the upper word is written. A read of the lower word captures the upper word, so that a following upper-word read returns a coherent pair. The live time value is also driven on a 64-bit output for timestamping logic.

Top module: `tod_trim_counter`

## Requirements
- R1: After rst_n is released, the control word, the trim word, the time value, the phase accumulator and the captured upper word are all zero.
- R2: Selector 0 is the control word. Bits 25:16 hold the nominal step in nanoseconds, bit 2 is run, bit 3 is bypass and bit 5 is soft clear. All other bits read back as zero (mask 0x03FF002C).
- R3: With run=1, bypass=0 and soft clear=0, each cycle adds the trim word (selector 1) into the accumulator modulo 2^32. On a carry out of that sum, the time value grows by the step on the same clock edge.
- R4: In a running cycle with no accumulator carry, the time value keeps its value.
- R5: With run=1 and bypass=1, the time value grows by the step every cycle and the accumulator does not advance.
- R6: With run=0, the time value and the accumulator both hold.
- R7: While soft clear is 1, the time value and the accumulator are forced to zero and the control and trim words keep their contents. After soft clear drops, accumulation restarts from zero.
- R8: A write to selector 2 only fills a staging word and leaves the time value unchanged. A write to selector 3 loads {written word, staging word} into the time value at that edge, overriding any step in that cycle. The accumulator keeps advancing through a load.
- R9: A read of selector 2 returns the current lower 32 bits and captures the current upper 32 bits. A read of selector 3 returns the captured word even after the time value has moved on.
- R10: A trim word written while running is used from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write register selector |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe (captures upper word on selector 2) |
| rd_sel | input | 2 | Read register selector |
| rd_data | output | 32 | Read data, combinational from rd_sel |
| tod_ns | output | 64 | Live time-of-day value in nanoseconds |

## Verification
On every cycle the assertions check the local cycle rules of the time value and the accumulator: clear to zero, load of the assembled word, step by the period, and hold when neither steps nor loads. They also check the capture and hold of the upper read word. Whether carries arrive at the right rate for a given trim word, and whether a rewritten trim word changes that rate, can only be seen in the bench's running scenarios. The same holds for the split load across the 32-bit boundary, for capture coherence while the value crosses an upper-word rollover, and for config survival through soft clear.

// File: rtl/tod_trim_pkg.sv
package tod_trim_pkg;

   typedef enum logic [1:0] {
      SEL_CTRL    = 2'd0,
      SEL_TRIM    = 2'd1,
      SEL_TIME_LO = 2'd2,
      SEL_TIME_HI = 2'd3
   } tod_sel_e;

   localparam int unsigned BIT_RUN    = 2;
   localparam int unsigned BIT_BYPASS = 3;
   localparam int unsigned BIT_SCLR   = 5;
   localparam int unsigned STEP_LSB   = 16;

endpackage

// File: rtl/tod_trim_regs.sv
module tod_trim_regs
   import tod_trim_pkg::*;
#(
   parameter int unsigned BUS_W  = 32,
   parameter int unsigned TRIM_W = 32,
   parameter int unsigned STEP_W = 10,
   parameter bit          HAS_BYPASS = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [1:0]          wr_sel,
   input  logic [BUS_W-1:0]    wr_data,
   output logic [STEP_W-1:0]   step_ns,
   output logic                run_en,
   output logic                bypass,
   output logic                soft_clr,
   output logic [TRIM_W-1:0]   trim,
   output logic                load_req,
   output logic [2*BUS_W-1:0]  load_value,
   output logic [BUS_W-1:0]    ctrl_word
);

   localparam int unsigned STEP_MSB = STEP_LSB + STEP_W - 1;

   if (STEP_MSB >= BUS_W) begin : g_bad_step
      $error("tod_trim_regs: step field does not fit the bus word");
   end
   if (TRIM_W > BUS_W) begin : g_bad_trim
      $error("tod_trim_regs: trim word wider than the bus word");
   end

   logic [STEP_W-1:0] step_q;
   logic              run_q;
   logic              sclr_q;
   logic [TRIM_W-1:0] trim_q;
   logic [BUS_W-1:0]  stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q  <= '0;
         run_q   <= 1'b0;
         sclr_q  <= 1'b0;
         trim_q  <= '0;
         stage_q <= '0;
      end else if (wr_en) begin
         unique case (wr_sel)
            SEL_CTRL: begin
               step_q <= wr_data[STEP_MSB:STEP_LSB];
               run_q  <= wr_data[BIT_RUN];
               sclr_q <= wr_data[BIT_SCLR];
            end
            SEL_TRIM:    trim_q  <= wr_data[TRIM_W-1:0];
            SEL_TIME_LO: stage_q <= wr_data;
            default: ;
         endcase
      end
   end

   if (HAS_BYPASS) begin : g_byp
      logic byp_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            byp_q <= 1'b0;
         else if (wr_en && wr_sel == SEL_CTRL)
            byp_q <= wr_data[BIT_BYPASS];
      end
      assign bypass = byp_q;
   end else begin : g_no_byp
      assign bypass = 1'b0;
   end

   assign step_ns    = step_q;
   assign run_en     = run_q;
   assign soft_clr   = sclr_q;
   assign trim       = trim_q;
   assign load_req   = wr_en && (wr_sel == SEL_TIME_HI);
   assign load_value = {wr_data, stage_q};

   always_comb begin
      ctrl_word                      = '0;
      ctrl_word[STEP_MSB:STEP_LSB]   = step_q;
      ctrl_word[BIT_RUN]             = run_q;
      ctrl_word[BIT_BYPASS]          = bypass;
      ctrl_word[BIT_SCLR]            = sclr_q;
   end

   AST_STAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel == SEL_TIME_LO) |=> $stable(stage_q)) // R8
      else $error("staging word changed without a lower-word write");

endmodule

// File: rtl/tod_trim_accum.sv
module tod_trim_accum #(
   parameter int unsigned TRIM_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              advance,
   input  logic [TRIM_W-1:0] trim,
   output logic              carry
);

   localparam int unsigned SUM_W = TRIM_W + 1;

   logic [TRIM_W-1:0] acc_q;
   logic [SUM_W-1:0]  sum;

   assign sum   = {1'b0, acc_q} + {1'b0, trim};
   assign carry = advance & sum[TRIM_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc_q <= '0;
      else if (clear)
         acc_q <= '0;
      else if (advance)
         acc_q <= sum[TRIM_W-1:0];
   end

   AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (acc_q == '0)) // R7
      else $error("accumulator not cleared");

   AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !advance) |=> $stable(acc_q)) // R6
      else $error("accumulator moved while idle");

endmodule

// File: rtl/tod_trim_count.sv
module tod_trim_count #(
   parameter int unsigned CNT_W  = 64,
   parameter int unsigned STEP_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              load,
   input  logic [CNT_W-1:0]  load_value,
   input  logic              step,
   input  logic [STEP_W-1:0] step_ns,
   output logic [CNT_W-1:0]  count
);

   if (STEP_W >= CNT_W) begin : g_bad_w
      $error("tod_trim_count: step wider than counter");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clear)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_value;
      else if (step)
         cnt_q <= cnt_q + CNT_W'(step_ns);
   end

   assign count = cnt_q;

   AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt_q == '0)) // R7
      else $error("counter not cleared");

   AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && load) |=> (cnt_q == $past(load_value))) // R8
      else $error("counter load mismatch");

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !load && step) |=> (cnt_q == $past(cnt_q) + CNT_W'($past(step_ns)))) // R3
      else $error("counter step mismatch");

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !load && !step) |=> $stable(cnt_q)) // R4
      else $error("counter moved without step");

endmodule

// File: rtl/tod_trim_counter.sv
module tod_trim_counter
   import tod_trim_pkg::*;
#(
   parameter int unsigned BUS_W      = 32,
   parameter int unsigned TRIM_W     = 32,
   parameter int unsigned STEP_W     = 10,
   parameter bit          HAS_BYPASS = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_sel,
   input  logic [BUS_W-1:0]   wr_data,
   input  logic               rd_en,
   input  logic [1:0]         rd_sel,
   output logic [BUS_W-1:0]   rd_data,
   output logic [2*BUS_W-1:0] tod_ns
);

   localparam int unsigned CNT_W = 2 * BUS_W;

   logic [STEP_W-1:0] step_ns;
   logic              run_en;
   logic              bypass;
   logic              soft_clr;
   logic [TRIM_W-1:0] trim;
   logic              load_req;
   logic [CNT_W-1:0]  load_value;
   logic [BUS_W-1:0]  ctrl_word;
   logic              acc_adv;
   logic              carry;
   logic              step;
   logic [CNT_W-1:0]  count;
   logic [BUS_W-1:0]  hi_capt_q;
   logic              capture;

   tod_trim_regs #(
      .BUS_W(BUS_W), .TRIM_W(TRIM_W), .STEP_W(STEP_W), .HAS_BYPASS(HAS_BYPASS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .step_ns(step_ns), .run_en(run_en), .bypass(bypass), .soft_clr(soft_clr),
      .trim(trim), .load_req(load_req), .load_value(load_value), .ctrl_word(ctrl_word)
   );

   if (HAS_BYPASS) begin : g_step_byp
      assign acc_adv = run_en && !bypass;
      assign step    = run_en && (bypass || carry);
   end else begin : g_step_plain
      assign acc_adv = run_en;
      assign step    = carry;
   end

   tod_trim_accum #(.TRIM_W(TRIM_W)) u_accum (
      .clk(clk), .rst_n(rst_n), .clear(soft_clr), .advance(acc_adv),
      .trim(trim), .carry(carry)
   );

   tod_trim_count #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_count (
      .clk(clk), .rst_n(rst_n), .clear(soft_clr), .load(load_req),
      .load_value(load_value), .step(step), .step_ns(step_ns), .count(count)
   );

   assign capture = rd_en && (rd_sel == SEL_TIME_LO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hi_capt_q <= '0;
      else if (capture)
         hi_capt_q <= count[CNT_W-1:BUS_W];
   end

   always_comb begin
      unique case (rd_sel)
         SEL_CTRL:    rd_data = ctrl_word;
         SEL_TRIM:    rd_data = BUS_W'(trim);
         SEL_TIME_LO: rd_data = count[BUS_W-1:0];
         default:     rd_data = hi_capt_q;
      endcase
   end

   assign tod_ns = count;

   AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (hi_capt_q == $past(tod_ns[CNT_W-1:BUS_W]))) // R9
      else $error("upper word not captured");

   AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(hi_capt_q)) // R9
      else $error("captured upper word drifted");

   AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !soft_clr && !load_req) |=> $stable(tod_ns)) // R6
      else $error("time moved while stopped");

endmodule

// File: tb/tod_trim_counter_test.sv
`timescale 1ns/1ps
module tod_trim_counter_test;

   localparam logic [31:0] CTRL_MASK = 32'h03FF_002C;

   typedef struct {
      logic [63:0] data;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [1:0]  rd_sel = '0;
   logic [31:0] rd_data;
   logic [63:0] tod_ns;

   int n_cmp = 0;
   int n_bad = 0;
   string phase = "R1";

   exp_t rd_q[$];
   exp_t tod_q[$];

   logic [31:0] m_ctrl = '0, m_trim = '0, m_stage = '0, m_capt = '0, m_acc = '0;
   logic [63:0] m_cnt = '0;

   always #10 clk = ~clk;

   tod_trim_counter uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .tod_ns(tod_ns)
   );

   function automatic logic [31:0] model_read(input logic [1:0] s);
      case (s)
         2'd0:    return m_ctrl;
         2'd1:    return m_trim;
         2'd2:    return m_cnt[31:0];
         default: return m_capt;
      endcase
   endfunction

   task automatic model_step(input logic w, input logic [1:0] ws, input logic [31:0] wd,
                             input logic r, input logic [1:0] rs);
      logic [32:0] s;
      logic [63:0] per;
      logic [63:0] ncnt;
      logic [31:0] nacc;
      per  = 64'(m_ctrl[25:16]);
      s    = {1'b0, m_acc} + {1'b0, m_trim};
      ncnt = m_cnt;
      nacc = m_acc;
      if (m_ctrl[5]) begin
         ncnt = '0; nacc = '0;
      end else begin
         if (m_ctrl[2] && !m_ctrl[3]) nacc = s[31:0];
         if (w && ws == 2'd3) ncnt = {wd, m_stage};
         else if (m_ctrl[2] && (m_ctrl[3] || s[32])) ncnt = m_cnt + per;
      end
      if (r && rs == 2'd2) m_capt = m_cnt[63:32];
      if (w) begin
         case (ws)
            2'd0: m_ctrl = wd & CTRL_MASK;
            2'd1: m_trim = wd;
            2'd2: m_stage = wd;
            default: ;
         endcase
      end
      m_cnt = ncnt;
      m_acc = nacc;
   endtask

   // driver: pushes expected items, then advances one clock
   task automatic cyc(input logic w, input logic [1:0] ws, input logic [31:0] wd,
                      input logic r, input logic [1:0] rs);
      exp_t it;
      wr_en = w; wr_sel = ws; wr_data = wd; rd_en = r; rd_sel = rs;
      if (r) begin
         it.data = 64'(model_read(rs)); it.tag = phase; rd_q.push_back(it);
      end
      it.data = m_cnt; it.tag = phase; tod_q.push_back(it);
      @(posedge clk);
      model_step(w, ws, wd, r, rs);
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 32'd0, 1'b0, 2'd0);
   endtask

   task automatic wr(input logic [1:0] ws, input logic [31:0] wd);
      cyc(1'b1, ws, wd, 1'b0, 2'd0);
   endtask

   task automatic rd(input logic [1:0] rs);
      cyc(1'b0, 2'd0, 32'd0, 1'b1, rs);
   endtask

   // monitor: pops and compares away from the clock edge
   initial begin
      exp_t it;
      forever begin
         @(negedge clk);
         #5;
         if (tod_q.size() > 0) begin
            it = tod_q.pop_front();
            n_cmp++;
            if (tod_ns !== it.data) begin
               n_bad++;
               $display("FAIL %s tod_ns actual=%h expected=%h", it.tag, tod_ns, it.data);
            end
         end
         if (rd_en) begin
            n_cmp++;
            if (rd_q.size() == 0) begin
               n_bad++;
               $display("FAIL %s read with no expected item actual=%h expected=none", phase, rd_data);
            end else begin
               it = rd_q.pop_front();
               if (rd_data !== it.data[31:0]) begin
                  n_bad++;
                  $display("FAIL %s rd_data actual=%h expected=%h", it.tag, rd_data, it.data[31:0]);
               end
            end
         end
      end
   end

   initial begin
      repeat (60000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      phase = "R1";
      rd(2'd0); rd(2'd1); rd(2'd2); rd(2'd3);

      phase = "R2";
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0);
      idle(2);

      phase = "R3";
      wr(2'd1, 32'h8000_0000);
      wr(2'd0, (32'd8 << 16) | 32'h4);
      idle(12);

      phase = "R10";
      wr(2'd1, 32'h5555_5556);
      idle(12);
      rd(2'd1);

      phase = "R4";
      wr(2'd1, 32'h0);
      idle(6);

      phase = "R5";
      wr(2'd0, (32'd25 << 16) | 32'hC);
      idle(6);

      phase = "R6";
      wr(2'd0, (32'd25 << 16));
      wr(2'd1, 32'hF000_0000);
      idle(6);

      phase = "R8";
      wr(2'd2, 32'hFFFF_FFF0);
      idle(3);
      wr(2'd0, (32'd8 << 16) | 32'hC);
      wr(2'd3, 32'h0000_0001);
      idle(3);

      phase = "R9";
      wr(2'd2, 32'hFFFF_FFF8);
      wr(2'd3, 32'h0000_0001);
      rd(2'd2);
      idle(2);
      rd(2'd3);
      rd(2'd2);
      rd(2'd3);

      phase = "R7";
      wr(2'd0, (32'd8 << 16) | 32'h24);
      idle(3);
      rd(2'd0);
      rd(2'd1);
      wr(2'd0, (32'd8 << 16) | 32'h4);
      idle(8);

      wr_en = 1'b0; rd_en = 1'b0;
      @(negedge clk);
      #6;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule